// File: doc/BRIEF.md
# Clock Register Shadow RAM

A byte-wide synchronous RAM of 2048 locations whose eight highest addresses are clock holding registers rather than plain storage. While refreshing is enabled, each one-second tick reloads the seven time registers from a bus that carries the live counter values. Software reads and writes the clock bytes through the same port it uses for ordinary RAM.

The control byte at the bottom of the clock window has two halt bits. The snapshot bit freezes the holding registers so that software can read a consistent time. The load bit also freezes them so that software can write new values into them. When software clears the load bit, the block pulses a load strobe for one cycle. It presents the seven holding bytes on a load bus so that the external counters can take them in a single step. The counters, the oscillator and any calibration arithmetic live outside this block.

Top module: `rtc_shadow_ram`

## Requirements
- R1: Writes to addresses 000h-7F7h are stored. A read of such an address returns the stored byte on rdata_o one clock after the address is presented.
- R2: Address 7F8h is the control byte. Addresses 7F9h-7FFh hold second, minute, hour, day, date, month and year. These map to byte k = addr-7F9h of live_i, at bits [8k+7:8k]. Reads of 7F9h-7FFh return the holding registers, never live_i directly.
- R3: On a clock where tick_i is high and neither halt bit is set, all seven holding registers load live_i together.
- R4: While control bit 6 (snapshot) is 1, ticks do not change the holding registers. After the bit is written back to 0, the first following tick refreshes them.
- R5: While control bit 7 (load) is 1, ticks do not refresh, and software writes to 7F9h-7FFh are stored and read back.
- R6: A write to 7F8h that changes bit 7 from 1 to 0 raises load_o for exactly one cycle on the next clock. In that same cycle, load_data_o carries the seven holding bytes as they stood at that write. No other write raises load_o.
- R7: A control write that sets a halt bit in the same cycle as a tick does not stop that tick's refresh. The halt applies from the next tick on.
- R8: Control bits 5..0 are stored and read back, and they have no effect on refresh or load.
- R9: With no halt bit set, a software write to a time byte in the same cycle as a tick loses to the refresh. Without a tick, the write is stored.
- R10: After reset, rdata_o, load_o, the control byte and all holding registers are 0.
- R11: A read and a write to the same address in the same cycle return the byte held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 11 | Byte address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable |
| rdata_o | output | 8 | Read data, one cycle after address |
| tick_i | input | 1 | One-second tick, one clock wide |
| live_i | input | 56 | Live counter values, second in the lowest byte |
| load_o | output | 1 | One-cycle load strobe for the counters |
| load_data_o | output | 56 | Values to load, valid with load_o |

## Verification
A behavioural model is compared with the block on every clock. The stimulus is built so that each halt path can be told apart from the others. Ticks arrive with no halt, with each halt bit set alone, and in the same cycle as the write that sets a halt; a wrong priority shows up as a snapshot that is one tick late or early. Software writes to time bytes happen both halted and unhalted, with and without a coinciding tick, and so separate refresh priority from plain storage. Control writes that clear the load bit, rewrite it as 1, or toggle only the low bits show whether the load strobe follows a true falling edge of that bit.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
  localparam int unsigned NUM_TIME  = 7;
  localparam int unsigned SNAP_BIT  = 6;
  localparam int unsigned LOAD_BIT  = 7;
  localparam int unsigned WIN_BITS  = 3;

  typedef enum logic [2:0] {
    SLOT_CTRL  = 3'd0,
    SLOT_SEC   = 3'd1,
    SLOT_MIN   = 3'd2,
    SLOT_HOUR  = 3'd3,
    SLOT_DAY   = 3'd4,
    SLOT_DATE  = 3'd5,
    SLOT_MONTH = 3'd6,
    SLOT_YEAR  = 3'd7
  } clk_slot_e;
endpackage

// File: rtl/rtc_ram_bank.sv
module rtc_ram_bank #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  // read-before-write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= mem_q[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_TIME = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [NUM_TIME*DATA_W-1:0] hold_i,
  output logic [DATA_W-1:0]          ctrl_o,
  output logic                       halt_o,
  output logic                       load_o,
  output logic [NUM_TIME*DATA_W-1:0] load_data_o
);
  import rtc_shadow_pkg::*;

  logic [DATA_W-1:0]          ctrl_q;
  logic                       load_q;
  logic [NUM_TIME*DATA_W-1:0] load_data_q;
  logic                       fire;

  assign fire = wr_i & ctrl_q[LOAD_BIT] & ~wdata_i[LOAD_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      load_q      <= 1'b0;
      load_data_q <= '0;
    end else begin
      if (wr_i) ctrl_q <= wdata_i;
      load_q <= fire;
      if (fire) load_data_q <= hold_i;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign halt_o      = ctrl_q[LOAD_BIT] | ctrl_q[SNAP_BIT];
  assign load_o      = load_q;
  assign load_data_o = load_data_q;
endmodule

// File: rtl/rtc_hold_regs.sv
module rtc_hold_regs #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_TIME = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       refresh_i,
  input  logic [NUM_TIME-1:0]        sw_we_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [NUM_TIME*DATA_W-1:0] live_i,
  output logic [NUM_TIME*DATA_W-1:0] hold_o
);
  for (genvar k = 0; k < NUM_TIME; k++) begin : g_slot
    logic [DATA_W-1:0] q;
    // refresh outranks a software write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q <= '0;
      else if (refresh_i)  q <= live_i[k*DATA_W +: DATA_W];
      else if (sw_we_i[k]) q <= wdata_i;
    end
    assign hold_o[k*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/rtc_shadow_ram.sv
module rtc_shadow_ram #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   we_i,
  output logic [DATA_W-1:0]      rdata_o,
  input  logic                   tick_i,
  input  logic [7*DATA_W-1:0]    live_i,
  output logic                   load_o,
  output logic [7*DATA_W-1:0]    load_data_o
);
  import rtc_shadow_pkg::*;

  localparam int unsigned BUS_W = NUM_TIME * DATA_W;

  logic                  in_win;
  logic [WIN_BITS-1:0]   slot;
  logic                  ram_we;
  logic                  ctrl_wr;
  logic [NUM_TIME-1:0]   sw_we;
  logic [DATA_W-1:0]     ram_rdata;
  logic [DATA_W-1:0]     ctrl_q;
  logic                  halt;
  logic                  refresh;
  logic [BUS_W-1:0]      hold_q;
  logic                  sel_win_q;
  logic [DATA_W-1:0]     win_rd_q;
  logic [DATA_W-1:0]     win_rd;

  assign in_win  = &addr_i[ADDR_W-1:WIN_BITS];
  assign slot    = addr_i[WIN_BITS-1:0];
  assign ram_we  = we_i & ~in_win;
  assign ctrl_wr = we_i & in_win & (slot == SLOT_CTRL);
  assign refresh = tick_i & ~halt;

  for (genvar k = 0; k < NUM_TIME; k++) begin : g_dec
    assign sw_we[k] = we_i & in_win & (slot == WIN_BITS'(k + 1));
  end

  always_comb begin
    win_rd = ctrl_q;
    for (int k = 0; k < NUM_TIME; k++) begin
      if (slot == WIN_BITS'(k + 1)) win_rd = hold_q[k*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_win_q <= 1'b0;
      win_rd_q  <= '0;
    end else begin
      sel_win_q <= in_win;
      win_rd_q  <= win_rd;
    end
  end

  assign rdata_o = sel_win_q ? win_rd_q : ram_rdata;

  rtc_ram_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .we_i    (ram_we),
    .rdata_o (ram_rdata)
  );

  rtc_ctrl_reg #(.DATA_W(DATA_W), .NUM_TIME(NUM_TIME)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (ctrl_wr),
    .wdata_i     (wdata_i),
    .hold_i      (hold_q),
    .ctrl_o      (ctrl_q),
    .halt_o      (halt),
    .load_o      (load_o),
    .load_data_o (load_data_o)
  );

  rtc_hold_regs #(.DATA_W(DATA_W), .NUM_TIME(NUM_TIME)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .refresh_i (refresh),
    .sw_we_i   (sw_we),
    .wdata_i   (wdata_i),
    .live_i    (live_i),
    .hold_o    (hold_q)
  );
endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic                we_i,
  input logic                tick_i,
  input logic [7*DATA_W-1:0] live_i,
  input logic                load_o,
  input logic [DATA_W-1:0]   ctrl_q,
  input logic [7*DATA_W-1:0] hold_q
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = {ADDR_W{1'b1}} - ADDR_W'(7);

  logic halted, time_wr, ctrl_wr;
  assign halted  = ctrl_q[7] | ctrl_q[6];
  assign time_wr = we_i && (addr_i > CTRL_ADDR);
  assign ctrl_wr = we_i && (addr_i == CTRL_ADDR);

  AST_REFRESH_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(tick_i && !halted) |-> hold_q == $past(live_i)); // R3

  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(halted) && !$past(time_wr) |-> $stable(hold_q)); // R4

  AST_LOAD_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $past(ctrl_wr && ctrl_q[7] && !wdata_i[7])); // R6

  AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o); // R6

  AST_CTRL_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(ctrl_wr) |-> ctrl_q == $past(wdata_i)); // R8
endmodule

bind rtc_shadow_ram rtc_shadow_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .tick_i  (tick_i),
  .live_i  (live_i),
  .load_o  (load_o),
  .ctrl_q  (ctrl_q),
  .hold_q  (hold_q)
);

// File: tb/sim_rtc_shadow_ram.sv
module sim_rtc_shadow_ram;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        we_i = 1'b0;
  logic [7:0]  rdata_o;
  logic        tick_i = 1'b0;
  logic [55:0] live_i = '0;
  logic        load_o;
  logic [55:0] load_data_o;

  int checks = 0;
  int fails  = 0;
  string tag = "R10";

  // reference model
  logic [7:0]  m_mem [2048];
  bit          m_val [2048];
  logic [7:0]  m_ctrl = '0;
  logic [7:0]  m_time [7];
  logic [7:0]  e_rd;
  bit          e_rd_val;
  bit          e_load;
  logic [55:0] e_ld_data;

  always #10 clk_i = ~clk_i;

  rtc_shadow_ram u0 (.*);

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic model_edge();
    bit halt_old;
    halt_old = m_ctrl[7] | m_ctrl[6];
    if (addr_i >= 11'h7F8) begin
      e_rd_val = 1;
      e_rd = (addr_i == 11'h7F8) ? m_ctrl : m_time[addr_i - 11'h7F9];
    end else begin
      e_rd_val = m_val[addr_i];
      e_rd = m_mem[addr_i];
    end
    e_load = we_i && addr_i == 11'h7F8 && m_ctrl[7] && !wdata_i[7];
    if (e_load) for (int k = 0; k < 7; k++) e_ld_data[k*8 +: 8] = m_time[k];
    if (we_i) begin
      if (addr_i < 11'h7F8) begin m_mem[addr_i] = wdata_i; m_val[addr_i] = 1; end
      else if (addr_i == 11'h7F8) m_ctrl = wdata_i;
      else if (!(tick_i && !halt_old)) m_time[addr_i - 11'h7F9] = wdata_i;
    end
    if (tick_i && !halt_old) for (int k = 0; k < 7; k++) m_time[k] = live_i[k*8 +: 8];
  endtask

  task automatic cyc(input logic [10:0] a, input logic [7:0] d, input bit w,
                     input bit t, input logic [55:0] lv);
    addr_i = a; wdata_i = d; we_i = w; tick_i = t; live_i = lv;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    if (e_rd_val) chk(tag, 64'(rdata_o), 64'(e_rd));
    chk(tag, 64'(load_o), 64'(e_load));
    if (e_load) chk(tag, 64'(load_data_o), 64'(e_ld_data));
  endtask

  task automatic rd(input logic [10:0] a);
    cyc(a, 8'h00, 0, 0, live_i);
  endtask

  task automatic rd_clock();
    for (int k = 0; k < 8; k++) rd(11'h7F8 + 11'(k));
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) m_val[i] = 0;
    for (int k = 0; k < 7; k++) m_time[k] = '0;
    repeat (3) @(negedge clk_i);
    tag = "R10";
    chk("R10", 64'(rdata_o), 64'h0);
    chk("R10", 64'(load_o), 64'h0);
    rst_ni = 1'b1;
    rd_clock();

    tag = "R1";
    cyc(11'h000, 8'hA5, 1, 0, '0);
    cyc(11'h7F7, 8'h3C, 1, 0, '0);
    cyc(11'h3FF, 8'hFF, 1, 0, '0);
    cyc(11'h005, 8'h00, 1, 0, '0);
    rd(11'h000); rd(11'h7F7); rd(11'h3FF); rd(11'h005);

    tag = "R11";
    cyc(11'h010, 8'h11, 1, 0, '0);
    cyc(11'h010, 8'h22, 1, 0, '0);
    rd(11'h010);
    cyc(11'h7F8, 8'h05, 1, 0, '0);
    cyc(11'h7F8, 8'h00, 1, 0, '0);

    tag = "R3";
    cyc(11'h000, 8'h00, 0, 1, 56'h19_12_31_07_23_59_58);
    rd_clock();

    tag = "R2";
    cyc(11'h7F9, 8'h00, 0, 0, 56'h20_01_01_01_00_00_00);
    rd_clock();

    tag = "R8";
    cyc(11'h7F8, 8'h3F, 1, 0, live_i);
    rd(11'h7F8);
    cyc(11'h7F8, 8'h15, 1, 1, 56'h21_02_03_04_05_06_07);
    rd_clock();

    tag = "R4";
    cyc(11'h7F8, 8'h40, 1, 0, live_i);
    cyc(11'h000, 8'h00, 0, 1, 56'h22_03_04_05_06_07_08);
    rd_clock();
    cyc(11'h7F8, 8'h00, 1, 0, live_i);
    rd_clock();
    cyc(11'h000, 8'h00, 0, 1, 56'h23_04_05_06_07_08_09);
    rd_clock();

    tag = "R7";
    cyc(11'h7F8, 8'h40, 1, 1, 56'h24_05_06_07_08_09_10);
    rd_clock();
    cyc(11'h000, 8'h00, 0, 1, 56'h25_06_07_08_09_10_11);
    rd_clock();
    cyc(11'h7F8, 8'h00, 1, 0, live_i);

    tag = "R5";
    cyc(11'h7F8, 8'h80, 1, 0, live_i);
    for (int k = 0; k < 7; k++) cyc(11'h7F9 + 11'(k), 8'h30 + 8'(k), 1, 0, live_i);
    cyc(11'h000, 8'h00, 0, 1, 56'h26_07_08_09_10_11_12);
    rd_clock();

    tag = "R6";
    cyc(11'h7F8, 8'h80, 1, 0, live_i);
    cyc(11'h7F8, 8'hC1, 1, 0, live_i);
    cyc(11'h7F8, 8'h41, 1, 0, live_i);
    rd(11'h7F8);
    cyc(11'h7F8, 8'h00, 1, 0, live_i);
    cyc(11'h7F8, 8'h80, 1, 0, live_i);
    cyc(11'h7F8, 8'h00, 1, 1, 56'h27_08_09_10_11_12_13);
    rd_clock();

    tag = "R9";
    cyc(11'h7FA, 8'h44, 1, 1, 56'h28_09_10_11_12_13_14);
    rd_clock();
    cyc(11'h7FB, 8'h55, 1, 0, live_i);
    rd_clock();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule